// File: doc/BRIEF.md
# Voting Session Phase Sequencer

This block runs one legislative vote session as a fixed series of three phases: accreditation, then voting, then collation. Each phase is shown to the rest of the system by one enable output. Member terminals use the accreditation and vote enables as their permission windows. The collation unit counts while its enable is high and answers with a completion strobe.

A mode input chooses who paces the session. In manual mode the presiding operator starts each phase with its own trigger pulse. The operator decides only when a phase starts. How long the accreditation and vote windows last is fixed, and no input of this block reaches any tally. In automatic mode an internal slow timer waits a fixed gap in each waiting state and then starts the next phase. After a collation it starts the next session by itself.

All lengths are counted in ticks. One tick lasts `TICK_DIV` clock cycles, and the tick prescaler restarts at the start of every window, so each window is an exact whole number of cycles. `ACC_TICKS`, `VOTE_TICKS` and `GAP_TICKS` must each be at least 1.

Top module: `vote_session_seq`

## Requirements
- R1: While reset is high, and in every cycle after reset until an accreditation is started, all three enables are low. In manual mode the block stays idle until `trig_accredit` is pulsed.
- R2: In idle, a `trig_accredit` pulse sampled at a clock edge raises `en_accredit` at that edge. The enable stays high for exactly `ACC_TICKS*TICK_DIV` cycles.
- R3: After accreditation ends, a `trig_vote` pulse raises `en_vote` at the sampling edge. The enable stays high for exactly `VOTE_TICKS*TICK_DIV` cycles.
- R4: After voting ends, a `trig_collate` pulse raises `en_collate`. It stays high for as long as `collate_done` is low. It falls at the edge that samples `collate_done` high, and the block returns to idle.
- R5: Phases only occur in the order accreditation, vote, collation. A `trig_vote` or `trig_collate` that does not name the next phase in that order has no effect.
- R6: A trigger that arrives while a phase enable is high has no effect. It does not lengthen the running window, and it is not remembered for later.
- R7: At most one of the three enables is high in any cycle.
- R8: In automatic mode the block waits `GAP_TICKS*TICK_DIV` cycles with all enables low before each phase, counted from the edge that ended the previous phase or collation. It then starts the next phase, with the same window lengths as in R2 and R3. When the mode input is raised in an idle block whose gap has already run out, the first accreditation starts `GAP_TICKS*TICK_DIV+1` cycles later.
- R9: In automatic mode the three manual triggers have no effect. In manual mode a waiting state never advances without its trigger.
- R10: `collate_done` outside the collation phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = self-running stepper, 0 = operator-triggered phases |
| trig_accredit | input | 1 | Operator pulse that starts accreditation |
| trig_vote | input | 1 | Operator pulse that starts voting |
| trig_collate | input | 1 | Operator pulse that starts collation |
| collate_done | input | 1 | Completion strobe from the collation unit |
| en_accredit | output | 1 | Accreditation window enable |
| en_vote | output | 1 | Vote window enable |
| en_collate | output | 1 | Collation enable |

## Verification
The bench builds the block with `TICK_DIV=4`, `ACC_TICKS=5`, `VOTE_TICKS=3` and `GAP_TICKS=2`. These values give windows of 20, 12 and 8 cycles. Because the three lengths differ, a swapped length, a prescaler off by one or a window cut short shows up as a wrong count. They are also short enough for the bench to run complete manual and automatic sessions. This covers the automatic restart after collation, and triggers injected in the middle of a window and in the middle of a gap.

// File: rtl/sess_pkg.sv
package sess_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ACC       = 3'd1,
        ST_WAIT_VOTE = 3'd2,
        ST_VOTE      = 3'd3,
        ST_WAIT_COLL = 3'd4,
        ST_COLL      = 3'd5
    } sess_state_e;

    // one bit per phase; used for enables and for operator requests
    typedef struct packed {
        logic accredit;
        logic vote;
        logic collate;
    } phase_vec_t;

    function automatic phase_vec_t state_enables(input sess_state_e s);
        phase_vec_t e;
        e = '0;
        case (s)
            ST_ACC:  e.accredit = 1'b1;
            ST_VOTE: e.vote     = 1'b1;
            ST_COLL: e.collate  = 1'b1;
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic is_waiting(input sess_state_e s);
        return (s == ST_IDLE) || (s == ST_WAIT_VOTE) || (s == ST_WAIT_COLL);
    endfunction

    function automatic sess_state_e phase_after_wait(input sess_state_e s);
        case (s)
            ST_IDLE:      return ST_ACC;
            ST_WAIT_VOTE: return ST_VOTE;
            ST_WAIT_COLL: return ST_COLL;
            default:      return ST_IDLE;
        endcase
    endfunction

    function automatic sess_state_e wait_after_phase(input sess_state_e s);
        case (s)
            ST_ACC:  return ST_WAIT_VOTE;
            ST_VOTE: return ST_WAIT_COLL;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sess_window_timer.sv
module sess_window_timer #(
    parameter int DIV   = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len_ticks,
    output logic             running,
    output logic             expire
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] cyc_q;
    logic [CNT_W-1:0] tick_q;
    logic [CNT_W-1:0] len_q;
    logic             run_q;
    logic             tick_wrap;

    assign tick_wrap = (cyc_q == DIV_LAST);
    assign expire    = run_q && tick_wrap && (tick_q == len_q - CNT_W'(1));
    assign running   = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cyc_q  <= '0;
            tick_q <= '0;
            len_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            cyc_q  <= '0;
            tick_q <= '0;
            len_q  <= len_ticks;
        end else if (run_q) begin
            if (expire) begin
                run_q <= 1'b0;
                cyc_q <= '0;
            end else if (tick_wrap) begin
                cyc_q  <= '0;
                tick_q <= tick_q + CNT_W'(1);
            end else begin
                cyc_q <= cyc_q + DIV_W'(1);
            end
        end
    end

    // R2: tick count never passes the loaded window length
    a_r2_tick_bound: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (tick_q < len_q));

endmodule

// File: rtl/sess_advance_sel.sv
module sess_advance_sel
    import sess_pkg::*;
(
    input  sess_state_e state,
    input  logic        auto_mode,
    input  phase_vec_t  req,
    input  logic        gap_expire,
    output logic        advance
);
    always_comb begin
        advance = 1'b0;
        if (is_waiting(state)) begin
            if (auto_mode) begin
                advance = gap_expire;
            end else begin
                case (state)
                    ST_IDLE:      advance = req.accredit;
                    ST_WAIT_VOTE: advance = req.vote;
                    ST_WAIT_COLL: advance = req.collate;
                    default:      advance = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/vote_session_seq.sv
module vote_session_seq
    import sess_pkg::*;
#(
    parameter int TICK_DIV   = 50_000_000,
    parameter int ACC_TICKS  = 30,
    parameter int VOTE_TICKS = 30,
    parameter int GAP_TICKS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_mode,
    input  logic trig_accredit,
    input  logic trig_vote,
    input  logic trig_collate,
    input  logic collate_done,
    output logic en_accredit,
    output logic en_vote,
    output logic en_collate
);
    localparam int MAX_TICKS = max3(ACC_TICKS, VOTE_TICKS, GAP_TICKS);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    sess_state_e      st_q, st_d;
    phase_vec_t       req, en;
    logic             advance;
    logic             tmr_start, tmr_running, tmr_expire;
    logic [CNT_W-1:0] tmr_len;

    assign req.accredit = trig_accredit;
    assign req.vote     = trig_vote;
    assign req.collate  = trig_collate;

    sess_advance_sel u_adv (
        .state      (st_q),
        .auto_mode  (auto_mode),
        .req        (req),
        .gap_expire (tmr_expire),
        .advance    (advance)
    );

    sess_window_timer #(.DIV(TICK_DIV), .CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (tmr_start),
        .len_ticks (tmr_len),
        .running   (tmr_running),
        .expire    (tmr_expire)
    );

    always_comb begin
        st_d      = st_q;
        tmr_start = 1'b0;
        tmr_len   = CNT_W'(GAP_TICKS);
        if (is_waiting(st_q)) begin
            if (advance) begin
                st_d = phase_after_wait(st_q);
                if (st_d == ST_ACC) begin
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(ACC_TICKS);
                end else if (st_d == ST_VOTE) begin
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(VOTE_TICKS);
                end
            end else if (auto_mode && !tmr_running) begin
                tmr_start = 1'b1;        // (re)arm the gap after a mode change
            end
        end else begin
            case (st_q)
                ST_ACC, ST_VOTE: begin
                    if (tmr_expire) begin
                        st_d      = wait_after_phase(st_q);
                        tmr_start = 1'b1;
                    end
                end
                ST_COLL: begin
                    if (collate_done) begin
                        st_d      = ST_IDLE;
                        tmr_start = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign en          = state_enables(st_q);
    assign en_accredit = en.accredit;
    assign en_vote     = en.vote;
    assign en_collate  = en.collate;

    // R1: reset leaves every enable low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!en_accredit && !en_vote && !en_collate));

    // R2: accreditation is held until its window timer runs out
    a_r2_acc_held: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACC && !tmr_expire) |=> en_accredit);

    // R4: collation holds until completion, then the block is idle
    a_r4_coll_holds: assert property (@(posedge clk) disable iff (rst)
        (en_collate && !collate_done) |=> en_collate);
    a_r4_coll_releases: assert property (@(posedge clk) disable iff (rst)
        (en_collate && collate_done) |=> (st_q == ST_IDLE));

    // R5: vote and collation only start out of their waiting states
    a_r5_vote_order: assert property (@(posedge clk) disable iff (rst)
        $rose(en_vote) |-> ($past(st_q) == ST_WAIT_VOTE));
    a_r5_coll_order: assert property (@(posedge clk) disable iff (rst)
        $rose(en_collate) |-> ($past(st_q) == ST_WAIT_COLL));

    // R9: manual idle does not move without the accreditation trigger
    a_r9_manual_idle: assert property (@(posedge clk) disable iff (rst)
        (!auto_mode && st_q == ST_IDLE && !trig_accredit) |=> (st_q == ST_IDLE));

endmodule

// File: tb/vote_session_seq_tb_top.sv
`timescale 1ns/1ps
module vote_session_seq_tb_top;
    localparam int DIV = 4;
    localparam int ACC = 5;
    localparam int VOT = 3;
    localparam int GAP = 2;
    localparam int W_ACC = ACC * DIV;
    localparam int W_VOT = VOT * DIV;
    localparam int W_GAP = GAP * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_mode = 1'b0;
    logic [3:0] stim = '0;   // bit0 acc, bit1 vote, bit2 collate, bit3 done
    logic       en_acc, en_vote, en_coll;

    int checks = 0;
    int errors = 0;
    int multi_hot = 0;

    always #10 clk = ~clk;

    vote_session_seq #(.TICK_DIV(DIV), .ACC_TICKS(ACC), .VOTE_TICKS(VOT),
                       .GAP_TICKS(GAP)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .auto_mode     (auto_mode),
        .trig_accredit (stim[0]),
        .trig_vote     (stim[1]),
        .trig_collate  (stim[2]),
        .collate_done  (stim[3]),
        .en_accredit   (en_acc),
        .en_vote       (en_vote),
        .en_collate    (en_coll)
    );

    // R7 monitor
    always @(negedge clk) begin
        if (!rst && (int'(en_acc) + int'(en_vote) + int'(en_coll) > 1))
            multi_hot++;
    end

    function automatic logic en_of(input int w);
        case (w)
            0:       return en_acc;
            1:       return en_vote;
            default: return en_coll;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one-cycle pulse on stimulus bits, starting at the current negedge
    task automatic pulse(input int idx);
        stim[idx] = 1'b1;
        @(negedge clk);
        stim = '0;
    endtask

    // count negedges while enable w equals lvl; apply mask at count inj_at
    task automatic measure(input int w, input logic lvl, input int inj_at,
                           input logic [3:0] mask, input int cap, output int n);
        n = 0;
        while (en_of(w) == lvl && n < cap) begin
            if (n == inj_at) stim = mask;
            @(negedge clk);
            stim = '0;
            n++;
        end
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 enables in reset", int'({en_acc, en_vote, en_coll}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 enables after reset", int'({en_acc, en_vote, en_coll}), 0);
        measure(0, 1'b0, -1, 4'b0, 30, n);
        chk("R1 idle without trigger", n, 30);
    endtask

    task automatic t_manual_session();
        int n;
        pulse(0);
        chk("R2 accredit raised", int'(en_acc), 1);
        measure(0, 1'b1, -1, 4'b0, 1000, n);
        chk("R2 accredit window", n, W_ACC);
        measure(1, 1'b0, -1, 4'b0, 15, n);
        chk("R9 manual wait holds", n, 15);
        pulse(1);
        chk("R3 vote raised", int'(en_vote), 1);
        measure(1, 1'b1, -1, 4'b0, 1000, n);
        chk("R3 vote window", n, W_VOT);
        pulse(2);
        chk("R4 collate raised", int'(en_coll), 1);
        measure(2, 1'b1, -1, 4'b0, 25, n);
        chk("R4 collate held", n, 25);
        pulse(3);
        chk("R4 collate released", int'(en_coll), 0);
        measure(0, 1'b0, -1, 4'b0, 20, n);
        chk("R4 idle after collation", n, 20);
    endtask

    task automatic t_order_and_ignore();
        int n;
        pulse(1);
        chk("R5 vote trigger in idle", int'(en_vote), 0);
        pulse(2);
        chk("R5 collate trigger in idle", int'(en_coll), 0);
        pulse(0);
        measure(0, 1'b1, 5, 4'b0011, 1000, n);
        chk("R6 accredit window with triggers", n, W_ACC);
        measure(1, 1'b0, 3, 4'b1100, 15, n);
        chk("R6 vote trigger not remembered", n, 15);
        chk("R5 collate before vote", int'(en_coll), 0);
        chk("R10 done outside collation", int'({en_acc, en_vote, en_coll}), 0);
        pulse(1);
        measure(1, 1'b1, 4, 4'b0101, 1000, n);
        chk("R10 vote window intact", n, W_VOT);
        pulse(2);
        pulse(3);
        repeat (12) @(negedge clk);
        chk("R4 idle after second session", int'({en_acc, en_vote, en_coll}), 0);
    endtask

    task automatic t_auto();
        int n;
        auto_mode = 1'b1;
        measure(0, 1'b0, -1, 4'b0, 100, n);
        chk("R8 first auto gap", n, W_GAP + 1);
        measure(0, 1'b1, -1, 4'b0, 1000, n);
        chk("R8 auto accredit window", n, W_ACC);
        measure(1, 1'b0, 2, 4'b0010, 100, n);
        chk("R9 auto ignores vote trigger", n, W_GAP);
        measure(1, 1'b1, -1, 4'b0, 1000, n);
        chk("R8 auto vote window", n, W_VOT);
        measure(2, 1'b0, -1, 4'b0, 100, n);
        chk("R8 auto gap before collate", n, W_GAP);
        measure(2, 1'b1, 4, 4'b0001, 10, n);
        chk("R4 auto collate held", n, 10);
        chk("R9 auto ignores accredit trigger", int'(en_acc), 0);
        pulse(3);
        chk("R4 auto collate released", int'(en_coll), 0);
        measure(0, 1'b0, -1, 4'b0, 100, n);
        chk("R8 auto restart gap", n, W_GAP);
        auto_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_manual_session();
        t_order_and_ignore();
        t_auto();
        chk("R7 one enable at most", multi_hot, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule